// File: doc/BRIEF.md
# LED PWM Generator with Shadowed Prescaler

This block drives one LED pin with a pulse-width modulated level. An 8-bit step counter splits every PWM period into 256 equal steps. A 12-bit prescale value sets how many selected ticks each step lasts, so one period spans 256 × (prescale + 1) ticks. The tick is either every cycle of the system clock or a one-cycle slow-tick strobe supplied from outside. All logic runs in that one clock domain.

Software controls the block through three word registers. The control word picks the mode (off, PWM or forced on), picks the tick source, requests a prescale transfer and triggers a soft reset. The level word holds the 8-bit duty value, which takes effect at once. The timing word holds the prescale value in a shadow copy. That copy reaches the active prescaler only when software requests a transfer, and then only at the next period boundary. This keeps a period from being cut short or stretched by a change made part-way through it.

Top module: `led_pwm_gen`

## Requirements
- R1: In PWM mode one output period lasts 256 × (P + 1) selected ticks, where P is the active prescale value. The output rises at the start of every period.
- R2: Let D be the duty value in the level word, bits [7:0]. The output stays high for D × (P + 1) ticks at the start of each period and is low for the rest. D = 0 keeps the output low at all times. D = 255 keeps it high at all times.
- R3: A write to the level word changes the output within the current period. The level word is at word address 1.
- R4: A write to the timing word (word address 2) goes only to the shadow copy, which reads back at once. The active prescale value (shadow bits [11:0]) does not change until a transfer takes place.
- R5: Writing 1 to control bit 6 requests a transfer. The bit reads back as 1 while the transfer is pending. The copy happens at the next period boundary and the bit then clears. Writing 0 to the bit does not cancel a pending request.
- R6: Control bits [1:0] select the mode. Value 2 is PWM. Value 3 drives the output high. Values 0 and 1 drive it low and hold both counters at zero.
- R7: Control bit 2 set makes every clock cycle a tick. Bit 2 clear makes only cycles with slow_tick high count as ticks.
- R8: A write with control bit 7 set clears all three registers, any pending transfer, the active prescale value and both counters. Bit 7 always reads back as 0.
- R9: Word address 0 is the control word, address 1 the level word and address 2 the timing word. Bits [15:8] of the level word and bits [23:12] of the timing word are plain storage that reads back as written. Addresses 3 to 5 read as zero and ignore writes. Unused bit positions read as zero.
- R10: After rst_n every register reads zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the fast tick source |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe used as the tick when the slow source is selected |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| led_out | output | 1 | Registered LED drive level |

## Verification
The period and duty are measured on the pin for several combinations of prescale and duty. A duty of 1 with prescale 2 shows that the high time scales with the prescaler. A duty of 254 separates a short low phase from a forced-high output. One run uses the slow strobe to tell the tick sources apart. A prescale write without a transfer request must leave the measured period unchanged, which separates the shadow from the active register. A duty change made mid-period must pull the pin low long before the period ends, which separates an immediate duty write from a buffered one. Duty values 0 and 255 and the forced modes are held for several hundred cycles to confirm the pin never toggles.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

  localparam int DUTY_W = 8;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  localparam int CFG_MODE_LSB = 0;
  localparam int CFG_FAST_BIT = 2;
  localparam int CFG_XFER_BIT = 6;
  localparam int CFG_SRST_BIT = 7;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_LEVEL = 1;
  localparam int ADDR_TIME  = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RSVD = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_ON   = 2'd3
  } pwm_mode_e;

  // Output level for one step of the period.
  function automatic logic level_for(pwm_mode_e m, logic [DUTY_W-1:0] duty,
                                     logic [DUTY_W-1:0] step_cnt);
    case (m)
      MODE_ON:  level_for = 1'b1;
      MODE_PWM: level_for = (duty == DUTY_MAX) ? 1'b1 : (step_cnt < duty);
      default:  level_for = 1'b0;
    endcase
  endfunction

  // Last step of a period reached on this step pulse.
  function automatic logic is_last_step(logic [DUTY_W-1:0] step_cnt);
    is_last_step = (step_cnt == DUTY_MAX);
  endfunction

endpackage

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
  import led_pwm_pkg::*;
#(
  parameter int LD_W   = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              period_end_i,
  output pwm_mode_e         mode_o,
  output logic              fast_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [LD_W-1:0]   active_ld_o,
  output logic              soft_rst_o
);
  localparam int LIM_W = 2 * DUTY_W;
  localparam int DLY_W = 2 * LD_W;

  pwm_mode_e         mode_q;
  logic              fast_q;
  logic              xfer_pend_q;
  logic [LIM_W-1:0]  level_q;
  logic [DLY_W-1:0]  shadow_q;
  logic [LD_W-1:0]   active_ld_q;

  logic wr_ctrl, wr_level, wr_time, xfer_evt;
  logic unused_wbits;

  assign wr_ctrl    = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_level   = wr_en_i && (addr_i == ADDR_W'(ADDR_LEVEL));
  assign wr_time    = wr_en_i && (addr_i == ADDR_W'(ADDR_TIME));
  assign soft_rst_o = wr_ctrl && wdata_i[CFG_SRST_BIT];
  assign xfer_evt   = xfer_pend_q && period_end_i;
  assign unused_wbits = ^{wdata_i[DATA_W-1:DLY_W], wdata_i[5:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFF;
      fast_q      <= 1'b0;
      xfer_pend_q <= 1'b0;
      level_q     <= '0;
      shadow_q    <= '0;
      active_ld_q <= '0;
    end else if (soft_rst_o) begin
      mode_q      <= MODE_OFF;
      fast_q      <= 1'b0;
      xfer_pend_q <= 1'b0;
      level_q     <= '0;
      shadow_q    <= '0;
      active_ld_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= pwm_mode_e'(wdata_i[CFG_MODE_LSB +: 2]);
        fast_q <= wdata_i[CFG_FAST_BIT];
      end
      if (wr_level) level_q  <= wdata_i[LIM_W-1:0];
      if (wr_time)  shadow_q <= wdata_i[DLY_W-1:0];
      if (xfer_evt) active_ld_q <= shadow_q[LD_W-1:0];
      if (wr_ctrl && wdata_i[CFG_XFER_BIT]) xfer_pend_q <= 1'b1;
      else if (xfer_evt)                    xfer_pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADDR_CTRL): begin
        rdata_o[CFG_MODE_LSB +: 2] = mode_q;
        rdata_o[CFG_FAST_BIT]      = fast_q;
        rdata_o[CFG_XFER_BIT]      = xfer_pend_q;
      end
      ADDR_W'(ADDR_LEVEL): rdata_o[LIM_W-1:0] = level_q;
      ADDR_W'(ADDR_TIME):  rdata_o[DLY_W-1:0] = shadow_q;
      default:             rdata_o = '0;
    endcase
  end

  assign mode_o      = mode_q;
  assign fast_o      = fast_q;
  assign duty_o      = level_q[DUTY_W-1:0];
  assign active_ld_o = active_ld_q;

  // R4: active prescale only moves on a transfer or a soft reset
  assert_ld_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_evt && !soft_rst_o) |=> $stable(active_ld_q));

  // R5: a pending request is consumed at the period boundary
  assert_xfer_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && !soft_rst_o && !(wr_ctrl && wdata_i[CFG_XFER_BIT])) |=> !xfer_pend_q);

  // R8: soft reset returns all state to defaults
  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (mode_q == MODE_OFF && level_q == '0 && shadow_q == '0 &&
                    !xfer_pend_q && active_ld_q == '0 && !fast_q));

endmodule

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
  parameter int LD_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            fast_i,
  input  logic            slow_tick_i,
  input  logic [LD_W-1:0] ld_i,
  output logic            step_o
);
  logic [LD_W-1:0] pre_cnt_q;
  logic            tick;
  logic            pre_wrap;

  assign tick     = fast_i || slow_tick_i;
  assign pre_wrap = (pre_cnt_q == ld_i);
  assign step_o   = !clr_i && tick && pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt_q <= '0;
    else if (clr_i)   pre_cnt_q <= '0;
    else if (tick)    pre_cnt_q <= pre_wrap ? '0 : pre_cnt_q + 1'b1;
  end

  // R1: the prescale counter never runs past the active prescale value
  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt_q <= ld_i);

  // R7: with no tick selected the prescaler holds its count
  assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_i && !slow_tick_i && !clr_i) |=> $stable(pre_cnt_q));

endmodule

// File: rtl/led_pwm_duty.sv
module led_pwm_duty
  import led_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  pwm_mode_e         mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              period_end_o,
  output logic              led_o
);
  logic [DUTY_W-1:0] step_cnt_q;
  logic              led_q;

  assign period_end_o = step_i && is_last_step(step_cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_cnt_q <= '0;
    else if (clr_i)  step_cnt_q <= '0;
    else if (step_i) step_cnt_q <= step_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= level_for(mode_i, duty_i, step_cnt_q);
  end

  assign led_o = led_q;

  // R1: a period boundary restarts the step count
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> (step_cnt_q == '0));

  // R2: duty zero keeps the pin low, full duty keeps it high
  assert_duty_zero_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PWM && duty_i == '0) |=> !led_q);
  assert_duty_full_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PWM && duty_i == DUTY_MAX) |=> led_q);

  // R6: forced modes
  assert_forced_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ON) |=> led_q);
  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_OFF || mode_i == MODE_RSVD) |=> (!led_q && step_cnt_q == '0));

endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen
  import led_pwm_pkg::*;
#(
  parameter int LD_W   = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              led_out
);
  pwm_mode_e         mode;
  logic              fast_sel;
  logic [DUTY_W-1:0] duty;
  logic [LD_W-1:0]   active_ld;
  logic              soft_rst;
  logic              period_end;
  logic              step;
  logic              cnt_clr;

  assign cnt_clr = soft_rst || (mode != MODE_PWM);

  led_pwm_regs #(.LD_W(LD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .period_end_i(period_end),
    .mode_o(mode), .fast_o(fast_sel), .duty_o(duty),
    .active_ld_o(active_ld), .soft_rst_o(soft_rst)
  );

  led_pwm_timebase #(.LD_W(LD_W)) u_time (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr),
    .fast_i(fast_sel), .slow_tick_i(slow_tick), .ld_i(active_ld),
    .step_o(step)
  );

  led_pwm_duty u_duty (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .step_i(step),
    .mode_i(mode), .duty_i(duty),
    .period_end_o(period_end), .led_o(led_out)
  );

endmodule

// File: tb/sim_led_pwm_gen.sv
module sim_led_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        led_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { int per; int hi; int req; } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  led_pwm_gen u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .led_out(led_out)
  );

  int slow_cnt = 0;
  always @(negedge clk) begin
    slow_cnt  = (slow_cnt == SLOW_DIV-1) ? 0 : slow_cnt + 1;
    slow_tick = (slow_cnt == SLOW_DIV-1);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected period and high time from the requirements
  function automatic int exp_per(input int p, input int div);
    return 256 * (p + 1) * div;
  endfunction
  function automatic int exp_hi(input int d, input int p, input int div);
    return d * (p + 1) * div;
  endfunction

  task automatic expect_wave(input int per, input int hi, input int req);
    sb_item_t it;
    it.per = per; it.hi = hi; it.req = req;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: measure one full period from a rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        sb_item_t it;
        logic prev;
        int hi, per;
        it = sb_q[0];
        prev = led_out;
        @(negedge clk);
        while (!(!prev && led_out)) begin
          prev = led_out;
          @(negedge clk);
        end
        hi = 0;
        while (led_out) begin hi++; @(negedge clk); end
        per = hi;
        while (!led_out) begin per++; @(negedge clk); end
        chk($sformatf("R%0d period", it.req), per, it.per);
        chk($sformatf("R%0d high", it.req), hi, it.hi);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic hold_level(input string req, input int n, input logic lvl);
    int wrong = 0;
    repeat (n) begin
      @(negedge clk);
      if (led_out !== lvl) wrong++;
    end
    chk(req, wrong, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R10: reset state
    rd(0, d); chk("R10 ctrl", d, 0);
    rd(1, d); chk("R10 level", d, 0);
    rd(2, d); chk("R10 time", d, 0);
    chk("R10 led", int'(led_out), 0);

    // R9: map and storage fields (mode 1 is off, so no transfer happens)
    wr(1, 32'h0000ABCD); rd(1, d); chk("R9 level readback", d, 32'hABCD);
    wr(2, 32'h00123456); rd(2, d); chk("R9 time readback", d, 32'h123456);
    wr(4, 32'h0000FFFF); rd(4, d); chk("R9 spare addr", d, 0);
    wr(0, 32'h0000007D); rd(0, d); chk("R9 ctrl readback", d, 32'h45);

    // R8: soft reset
    wr(0, 32'h00000080);
    rd(0, d); chk("R8 ctrl cleared", d, 0);
    rd(1, d); chk("R8 level cleared", d, 0);
    rd(2, d); chk("R8 time cleared", d, 0);

    // R6: modes
    wr(1, 128);
    wr(0, 32'h3); hold_level("R6 forced on", 300, 1'b1);
    wr(0, 32'h0); idle(2); hold_level("R6 off low", 300, 1'b0);
    wr(0, 32'h5); idle(2); hold_level("R6 mode1 low", 300, 1'b0);

    // R1 R2: fast tick, prescale 0, duty 64
    wr(1, 64);
    wr(0, 32'h6);
    expect_wave(exp_per(0, 1), exp_hi(64, 0, 1), 1);

    // R1 R2 R5: prescale 2, duty 1
    wr(1, 1); wr(2, 2); wr(0, 32'h46);
    idle(800);
    rd(0, d); chk("R5 pending cleared", d & 32'h40, 0);
    expect_wave(exp_per(2, 1), exp_hi(1, 2, 1), 2);

    // prescale back to 0, duty 254
    wr(1, 254); wr(2, 0); wr(0, 32'h46);
    idle(800);
    expect_wave(exp_per(0, 1), exp_hi(254, 0, 1), 2);

    // R4: shadow write without a transfer leaves the period alone
    wr(1, 64); wr(2, 3);
    rd(2, d); chk("R4 shadow readback", d, 3);
    expect_wave(exp_per(0, 1), exp_hi(64, 0, 1), 4);
    // R5: request the transfer
    wr(0, 32'h46);
    rd(0, d); chk("R5 pending set", d & 32'h40, 32'h40);
    idle(300);
    rd(0, d); chk("R5 pending done", d & 32'h40, 0);
    expect_wave(exp_per(3, 1), exp_hi(64, 3, 1), 5);

    // R2: duty extremes
    wr(0, 32'h80); wr(1, 0); wr(0, 32'h6); idle(2);
    hold_level("R2 duty zero low", 600, 1'b0);
    wr(1, 255); idle(2);
    hold_level("R2 duty full high", 600, 1'b1);

    // R3: duty change mid-period acts at once
    wr(1, 200);
    begin
      logic prev;
      prev = led_out;
      @(negedge clk);
      while (!(!prev && led_out)) begin prev = led_out; @(negedge clk); end
    end
    idle(40);
    wr(1, 10);
    idle(3);
    chk("R3 immediate duty", int'(led_out), 0);

    // R7: slow tick source
    wr(0, 32'h80); wr(1, 128); wr(0, 32'h2);
    expect_wave(exp_per(0, SLOW_DIV), exp_hi(128, 0, SLOW_DIV), 7);

    finish_run();
  end

endmodule